// File: doc/BRIEF.md
# Receive Credit Doorbell Writer

This block returns buffer-space credits for one receive queue to the hardware with a single doorbell register write. Neighbouring logic reports newly freed credits through an increment input. The block adds them into a pending count. When a push is requested and the pending count is non-zero, the block builds one 32-bit doorbell word and offers it, with the queue index, on a simple valid/ready handshake towards the register bus.

The doorbell word uses a special command encoding. A marker bit flags the write as a command rather than a plain write-pointer update. A 3-bit command field selects the credit-return operation. The low byte carries the number of credits, clamped to 127. Once the bus accepts the word, the amount captured for that write is removed from the pending count. Any credit above the clamp limit is dropped. Credits that arrived during or after the issue cycle are kept for a later push.

Top module: `cdb_credit_doorbell`

## Requirements
- R1: While reset is asserted and in the cycle after it, `db_valid` is 0, `db_word` is 0 and the pending count is 0.
- R2: A push request that finds a pending count of zero issues no write: `db_valid` stays 0.
- R3: The credit count in a write equals the smaller of the pending count (sampled in the push cycle) and 127.
- R4: In every offered word, bit 11 is 1, bits 10:8 (the command field) are 000, the credit-return code, and bits 31:12 are 0.
- R5: Bits 7:0 of the offered word hold the credit count; a push sampled in cycle t drives `db_valid` high from cycle t+1.
- R6: After the write is accepted, the captured amount leaves the pending count, including any excess above 127. With no new increments, a later push issues nothing.
- R7: A credit increment in the same cycle as the acceptance is kept and is sent by the next push.
- R8: `db_valid`, `db_word` and `db_queue` hold steady until `db_ready` is seen high; `db_valid` drops in the cycle after acceptance.
- R9: A push request while a write is outstanding is ignored: no second write follows the acceptance unless a new push arrives.
- R10: Increments that arrive in the issue cycle or while the write waits for `db_ready` are not part of that write and are sent by the next push.
- R11: `db_queue` carries the value of `queue_sel` captured in the push cycle, unaffected by later changes of `queue_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| queue_sel | input | QW | Receive queue index addressed by the doorbell |
| inc_valid | input | 1 | Credit increment strobe |
| inc_amount | input | INC_W | Credits added when `inc_valid` is high |
| push_req | input | 1 | Request to send the pending credits |
| db_ready | input | 1 | Register bus accepts the offered write |
| db_valid | output | 1 | Doorbell write offered |
| db_queue | output | QW | Queue index of the offered write |
| db_word | output | 32 | Doorbell word: marker, command, credit count |

## Verification
The checker examines the following on every cycle: the fixed shape of the word (marker, command code, zero upper bits), the clamped count against the pending count seen in the push cycle, the absence of writes when nothing is pending, and the stability of an offered write until it is accepted. Some behaviour only shows across several pushes, so only the bench scenarios can demonstrate it. This covers the discarding of excess credit, increments kept when they coincide with the issue or the acceptance, and pushes ignored while a write is outstanding. The bench makes these visible through the count in the next doorbell word.

// File: rtl/cdb_pkg.sv
package cdb_pkg;

    localparam int DB_W        = 32;
    localparam int CNT_FIELD_W = 8;
    localparam int CMD_W       = 3;
    localparam int HI_W        = DB_W - CNT_FIELD_W - CMD_W - 1;
    localparam int CREDIT_CAP  = 127;

    localparam logic [CMD_W-1:0] CMD_RETURN_CREDITS = 3'd0;

    // Doorbell layout, MSB first: zero bits, marker, command, count
    typedef struct packed {
        logic [HI_W-1:0]        zero_hi;
        logic                   marker;
        logic [CMD_W-1:0]       cmd;
        logic [CNT_FIELD_W-1:0] count;
    } db_word_t;

    typedef enum logic [0:0] {
        ISS_IDLE = 1'b0,
        ISS_WAIT = 1'b1
    } issue_state_e;

    function automatic db_word_t make_credit_word(input logic [CNT_FIELD_W-1:0] n);
        db_word_t w;
        w.zero_hi = '0;
        w.marker  = 1'b1;
        w.cmd     = CMD_RETURN_CREDITS;
        w.count   = n;
        return w;
    endfunction

endpackage

// File: rtl/cdb_pending_acc.sv
module cdb_pending_acc #(
    parameter int PEND_W = 16,
    parameter int INC_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inc_valid,
    input  logic [INC_W-1:0]  inc_amount,
    input  logic              sub_en,
    input  logic [PEND_W-1:0] sub_amount,
    output logic [PEND_W-1:0] pend_q
);
    localparam int SUM_W = PEND_W + 1;
    localparam logic [SUM_W-1:0] SAT_VAL = {1'b0, {PEND_W{1'b1}}};

    logic [PEND_W-1:0] base;
    logic [SUM_W-1:0]  addend;
    logic [SUM_W-1:0]  sum;
    logic [PEND_W-1:0] pend_d;

    always_comb begin
        base   = sub_en ? (pend_q - sub_amount) : pend_q;
        addend = inc_valid ? SUM_W'(inc_amount) : '0;
        sum    = {1'b0, base} + addend;
        pend_d = (sum > SAT_VAL) ? SAT_VAL[PEND_W-1:0] : sum[PEND_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_d;
    end
endmodule

// File: rtl/cdb_word_pack.sv
module cdb_word_pack
    import cdb_pkg::*;
#(
    parameter int PEND_W = 16
) (
    input  logic [PEND_W-1:0] pend,
    output db_word_t          word,
    output logic              nonzero
);
    localparam logic [PEND_W-1:0] CAP = PEND_W'(CREDIT_CAP);

    logic [CNT_FIELD_W-1:0] clamped;

    always_comb begin
        clamped = (pend > CAP) ? CAP[CNT_FIELD_W-1:0] : pend[CNT_FIELD_W-1:0];
        word    = make_credit_word(clamped);
        nonzero = (pend != '0);
    end
endmodule

// File: rtl/cdb_issue_ctl.sv
module cdb_issue_ctl
    import cdb_pkg::*;
#(
    parameter int PEND_W = 16,
    parameter int QW     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_req,
    input  logic              nonzero,
    input  db_word_t          word_in,
    input  logic [PEND_W-1:0] pend_in,
    input  logic [QW-1:0]     queue_in,
    input  logic              db_ready,
    output logic              db_valid,
    output db_word_t          db_word,
    output logic [QW-1:0]     db_queue,
    output logic              sub_en,
    output logic [PEND_W-1:0] sub_amount
);
    issue_state_e      state_q;
    logic [PEND_W-1:0] snap_q;
    logic              start;

    assign start      = (state_q == ISS_IDLE) && push_req && nonzero;
    assign db_valid   = (state_q == ISS_WAIT);
    assign sub_en     = db_valid && db_ready;
    assign sub_amount = snap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ISS_IDLE;
            snap_q   <= '0;
            db_word  <= '0;
            db_queue <= '0;
        end else begin
            case (state_q)
                ISS_IDLE: if (start) begin
                    state_q  <= ISS_WAIT;
                    snap_q   <= pend_in;
                    db_word  <= word_in;
                    db_queue <= queue_in;
                end
                ISS_WAIT: if (db_ready) begin
                    state_q <= ISS_IDLE;
                end
                default: state_q <= ISS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cdb_credit_doorbell.sv
module cdb_credit_doorbell
    import cdb_pkg::*;
#(
    parameter int PEND_W = 16,
    parameter int INC_W  = 8,
    parameter int QW     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [QW-1:0]    queue_sel,
    input  logic             inc_valid,
    input  logic [INC_W-1:0] inc_amount,
    input  logic             push_req,
    input  logic             db_ready,
    output logic             db_valid,
    output logic [QW-1:0]    db_queue,
    output logic [DB_W-1:0]  db_word
);
    logic [PEND_W-1:0] pend_q;
    logic [PEND_W-1:0] sub_amount;
    logic              sub_en;
    logic              nonzero;
    db_word_t          packed_word;
    db_word_t          held_word;

    cdb_pending_acc #(.PEND_W(PEND_W), .INC_W(INC_W)) u_acc (
        .clk        (clk),
        .rst        (rst),
        .inc_valid  (inc_valid),
        .inc_amount (inc_amount),
        .sub_en     (sub_en),
        .sub_amount (sub_amount),
        .pend_q     (pend_q)
    );

    cdb_word_pack #(.PEND_W(PEND_W)) u_pack (
        .pend    (pend_q),
        .word    (packed_word),
        .nonzero (nonzero)
    );

    cdb_issue_ctl #(.PEND_W(PEND_W), .QW(QW)) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .push_req   (push_req),
        .nonzero    (nonzero),
        .word_in    (packed_word),
        .pend_in    (pend_q),
        .queue_in   (queue_sel),
        .db_ready   (db_ready),
        .db_valid   (db_valid),
        .db_word    (held_word),
        .db_queue   (db_queue),
        .sub_en     (sub_en),
        .sub_amount (sub_amount)
    );

    assign db_word = held_word;
endmodule

// File: rtl/cdb_checker.sv
module cdb_checker #(
    parameter int PEND_W = 16,
    parameter int QW     = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              db_valid,
    input logic              db_ready,
    input logic [31:0]       db_word,
    input logic [QW-1:0]     db_queue,
    input logic [PEND_W-1:0] pend_q
);
    localparam logic [PEND_W-1:0] CAP = PEND_W'(127);

    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!db_valid && db_word == 32'd0)); // R1

    AST_NO_EMPTY_WRITE: assert property (@(posedge clk) disable iff (rst)
        $rose(db_valid) |-> ($past(pend_q) != '0)); // R2

    AST_CLAMPED_COUNT: assert property (@(posedge clk) disable iff (rst)
        $rose(db_valid) |-> (db_word[7:0] ==
            (($past(pend_q) > CAP) ? 8'd127 : $past(pend_q[7:0])))); // R3

    AST_WORD_SHAPE: assert property (@(posedge clk) disable iff (rst)
        db_valid |-> (db_word[31:8] == 24'h000008)); // R4

    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        db_valid |-> (db_word[7:0] != 8'd0 && db_word[7] == 1'b0)); // R5

    AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (rst)
        (db_valid && !db_ready) |=> (db_valid && $stable(db_word) && $stable(db_queue))); // R8

    AST_DROP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (db_valid && db_ready) |=> !db_valid); // R8
endmodule

bind cdb_credit_doorbell cdb_checker #(.PEND_W(PEND_W), .QW(QW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .db_valid (db_valid),
    .db_ready (db_ready),
    .db_word  (db_word),
    .db_queue (db_queue),
    .pend_q   (pend_q)
);

// File: tb/tb_cdb_credit_doorbell.sv
module tb_cdb_credit_doorbell;
    localparam int CLK_PERIOD = 10;
    localparam int QW = 4;
    localparam int NVEC = 6;

    // vector table: increment count, amount per increment, expected credit count (0 = no write)
    localparam int V_N   [NVEC] = '{0, 1, 1,   1,   3,   2};
    localparam int V_AMT [NVEC] = '{0, 5, 127, 128, 100, 1};
    localparam int V_EXP [NVEC] = '{0, 5, 127, 127, 127, 2};

    logic          clk = 1'b0;
    logic          rst;
    logic [QW-1:0] queue_sel;
    logic          inc_valid;
    logic [7:0]    inc_amount;
    logic          push_req;
    logic          db_ready;
    logic          db_valid;
    logic [QW-1:0] db_queue;
    logic [31:0]   db_word;

    int checks = 0;
    int failures = 0;
    logic [31:0] held;

    always #(CLK_PERIOD/2) clk = ~clk;

    cdb_credit_doorbell #(.PEND_W(16), .INC_W(8), .QW(QW)) dut (
        .clk(clk), .rst(rst), .queue_sel(queue_sel), .inc_valid(inc_valid),
        .inc_amount(inc_amount), .push_req(push_req), .db_ready(db_ready),
        .db_valid(db_valid), .db_queue(db_queue), .db_word(db_word)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input int n);
        return 32'h0000_0800 | 32'(n);
    endfunction

    // all tasks start and end just after a falling edge
    task automatic add_credit(input int amt);
        inc_valid = 1'b1; inc_amount = amt[7:0];
        @(negedge clk);
        inc_valid = 1'b0; inc_amount = '0;
    endtask

    task automatic push_expect(input int n, input string req);
        push_req = 1'b1;
        @(negedge clk);
        push_req = 1'b0;
        if (n == 0) begin
            check(db_valid == 1'b0, req, 32'(db_valid), 32'd0);
            @(negedge clk);
            check(db_valid == 1'b0, req, 32'(db_valid), 32'd0);
        end else begin
            check(db_valid == 1'b1, req, 32'(db_valid), 32'd1);
            check(db_word == exp_word(n), req, db_word, exp_word(n));
        end
    endtask

    task automatic accept_write(input string req);
        db_ready = 1'b1;
        @(negedge clk);
        db_ready = 1'b0;
        check(db_valid == 1'b0, req, 32'(db_valid), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; queue_sel = '0; inc_valid = 1'b0; inc_amount = '0;
        push_req = 1'b0; db_ready = 1'b0;
        repeat (3) @(negedge clk);
        check(db_valid == 1'b0, "R1", 32'(db_valid), 32'd0);
        check(db_word == 32'd0, "R1", db_word, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(db_valid == 1'b0, "R1", 32'(db_valid), 32'd0);
        push_expect(0, "R1 empty after reset");

        // table-driven pass: R2 zero pending, R3/R5 clamp and count, R4 shape
        for (int i = 0; i < NVEC; i++) begin
            for (int k = 0; k < V_N[i]; k++) add_credit(V_AMT[i]);
            push_expect(V_EXP[i], (V_EXP[i] == 0) ? "R2" : "R3,R4,R5");
            if (V_EXP[i] != 0) accept_write("R8");
        end

        // R6: excess above 127 is discarded
        add_credit(200); add_credit(100);
        push_expect(127, "R6");
        accept_write("R6");
        push_expect(0, "R6 excess dropped");

        // R8 hold, R9 push ignored, R10 increments while waiting, R11 queue capture
        queue_sel = 4'd5;
        add_credit(3);
        push_expect(3, "R8");
        held = db_word;
        queue_sel = 4'd2;
        add_credit(9);
        push_req = 1'b1;
        @(negedge clk);
        push_req = 1'b0;
        @(negedge clk);
        check(db_valid == 1'b1, "R8", 32'(db_valid), 32'd1);
        check(db_word == held, "R8,R9", db_word, held);
        check(db_queue == 4'd5, "R11", 32'(db_queue), 32'd5);
        accept_write("R9");
        @(negedge clk);
        check(db_valid == 1'b0, "R9 no second write", 32'(db_valid), 32'd0);
        push_expect(9, "R10");
        check(db_queue == 4'd2, "R11", 32'(db_queue), 32'd2);
        accept_write("R8");

        // R7: increment in the acceptance cycle is kept
        add_credit(2);
        push_expect(2, "R7");
        inc_valid = 1'b1; inc_amount = 8'd4; db_ready = 1'b1;
        @(negedge clk);
        inc_valid = 1'b0; inc_amount = '0; db_ready = 1'b0;
        push_expect(4, "R7");
        accept_write("R7");

        // R10: increment in the issue cycle goes to the next write
        add_credit(3);
        push_req = 1'b1; inc_valid = 1'b1; inc_amount = 8'd6;
        @(negedge clk);
        push_req = 1'b0; inc_valid = 1'b0; inc_amount = '0;
        check(db_word == exp_word(3), "R10", db_word, exp_word(3));
        accept_write("R10");
        push_expect(6, "R10");
        accept_write("R10");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule